// File: doc/BRIEF.md
# Fractional-N Main Divider with Modulo Accumulator

This block divides a fast input clock by a programmable integer ratio N and emits one single-cycle pulse at the end of every divide cycle. A small accumulator adds a 3-bit fractional increment at each pulse, wrapping at a selectable modulus of 5 or 8. Whenever that addition wraps, the following divide cycle is stretched to N+1. Over one full accumulator period, the average ratio is therefore N plus the increment divided by the modulus.

New settings (ratio, increment, modulus select) arrive through a valid/ready port. An accepted word waits in a shadow copy and takes effect only at the next divide-cycle boundary. Until then the port holds ready low, which is its only form of back-pressure. Each output pulse opens a compensation window that lasts a fixed number of input cycles. During that window the accumulator contents stay stable, so a later analog stage can size its correction pulse from them. A power-down input freezes the divider in a known state. On release, counting restarts cleanly from the active ratio.

Top module: `frac_n_divider`

## Requirements
- R1: While reset is asserted and immediately after it is released: `div_pulse` and `comp_win` are 0, `acc_value` is 0 and `cfg_ready` is 1. The settings in force are ratio RESET_N (default 512), increment 0 and modulus 8. The first pulse appears on the RESET_N-th cycle after reset is released.
- R2: `div_pulse` is high for exactly one input cycle. Consecutive pulses are exactly N cycles apart when no wrap occurred at the earlier pulse.
- R3: At each pulse the increment is added to the accumulator modulo Q, where Q = 5 when `cfg_mod5` is 1 and Q = 8 when it is 0. The new value is visible on `acc_value` from the cycle after the pulse and holds until the next pulse. If the sum reached Q, the next interval is N+1 cycles.
- R4: An increment of Q or more is reduced by Q before it is added, so each pulse can wrap at most once.
- R5: A configuration word is taken on a cycle with `cfg_valid` and `cfg_ready` both high. `cfg_ready` is 0 from the following cycle until the next pulse has been taken.
- R6: An accepted word governs nothing before the next pulse. At that pulse, the accumulator step and the interval that follows use the new ratio, increment and modulus.
- R7: When an applied word changes the modulus, the accumulator is cleared to 0 at that pulse, no wrap is counted, and the following interval is N.
- R8: A ratio below N_MIN (default 512) is raised to N_MIN when it is accepted.
- R9: `comp_win` is high for exactly WIN_LEN (default 128) consecutive cycles, starting in the cycle after each pulse.
- R10: While `pwr_down` is high there is no pulse, `comp_win` is 0 and the accumulator is held at 0. Once `pwr_down` is low again, the first pulse comes on the N-th cycle, where N is the active ratio.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock being divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_down | input | 1 | Holds the divider stopped and cleared while high |
| cfg_valid | input | 1 | Configuration word offered |
| cfg_ready | output | 1 | Shadow slot free; word taken when valid is also high |
| cfg_n | input | 16 | Integer ratio N |
| cfg_nf | input | 3 | Fractional increment |
| cfg_mod5 | input | 1 | Modulus select: 1 gives 5, 0 gives 8 |
| div_pulse | output | 1 | One-cycle pulse at each terminal count |
| acc_value | output | 3 | Accumulator contents, stable during the window |
| comp_win | output | 1 | Compensation window after each pulse |

## Verification
The assertions assume that every period is longer than the compensation window. The ratio clamp guarantees this, so the window-closing and single-cycle pulse properties are never tested with short ratios. The ready properties assume that a word is offered only while ready is high. The bench therefore raises `cfg_valid` for one cycle, only after it has seen ready high, and never leaves a word waiting across a boundary. Power-down is entered and left only in mid-period, away from a pulse, so each property is checked against well-defined counting.

// File: rtl/frac_div_pkg.sv
package frac_div_pkg;
  localparam int unsigned DIV_N_W  = 16;
  localparam int unsigned DIV_NF_W = 3;
  localparam int unsigned DIV_ACC_W = 3;
  localparam int unsigned DIV_Q_W  = DIV_ACC_W + 1;

  typedef struct packed {
    logic [DIV_N_W-1:0]  n;
    logic [DIV_NF_W-1:0] nf;
    logic                mod5;
  } div_cfg_t;

  function automatic logic [DIV_Q_W-1:0] modulus_of(input logic mod5);
    return mod5 ? DIV_Q_W'(5) : DIV_Q_W'(8);
  endfunction
endpackage

// File: rtl/frac_cfg_shadow.sv
module frac_cfg_shadow
  import frac_div_pkg::*;
#(
  parameter int unsigned N_MIN   = 512,
  parameter int unsigned RESET_N = 512
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  div_cfg_t            in_cfg,
  input  logic                boundary,
  output logic [DIV_N_W-1:0]  act_n,
  output div_cfg_t            nxt_cfg,
  output logic                mod_swap
);
  div_cfg_t act_q, shadow_q;
  logic     pending_q;
  logic     accept;

  function automatic div_cfg_t clamp_cfg(input div_cfg_t c);
    div_cfg_t r;
    r = c;
    if (c.n < DIV_N_W'(N_MIN)) r.n = DIV_N_W'(N_MIN);
    return r;
  endfunction

  assign in_ready = !pending_q;
  assign accept   = in_valid && !pending_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending_q <= 1'b0;
      shadow_q  <= '0;
      act_q     <= '{n: DIV_N_W'(RESET_N), nf: '0, mod5: 1'b0};
    end else if (accept) begin
      shadow_q  <= clamp_cfg(in_cfg);
      pending_q <= 1'b1;
    end else if (boundary && pending_q) begin
      act_q     <= shadow_q;
      pending_q <= 1'b0;
    end
  end

  assign act_n    = act_q.n;
  assign nxt_cfg  = pending_q ? shadow_q : act_q;
  assign mod_swap = pending_q && (shadow_q.mod5 != act_q.mod5);
endmodule

// File: rtl/frac_accum.sv
module frac_accum
  import frac_div_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clear,
  input  logic                 boundary,
  input  logic                 mod_swap,
  input  logic [DIV_NF_W-1:0]  nf,
  input  logic                 mod5,
  output logic [DIV_ACC_W-1:0] acc,
  output logic                 carry
);
  logic [DIV_Q_W-1:0]   q, nf_w, nf_eff, sum;
  logic                 wrap;
  logic [DIV_ACC_W-1:0] acc_nxt;

  always_comb begin
    q       = modulus_of(mod5);
    nf_w    = DIV_Q_W'(nf);
    nf_eff  = (nf_w >= q) ? nf_w - q : nf_w;
    sum     = DIV_Q_W'(acc) + nf_eff;
    wrap    = (sum >= q);
    acc_nxt = DIV_ACC_W'(wrap ? sum - q : sum);
    carry   = boundary && !mod_swap && wrap;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         acc <= '0;
    else if (clear)     acc <= '0;
    else if (boundary)  acc <= mod_swap ? '0 : acc_nxt;
  end
endmodule

// File: rtl/frac_cycle_counter.sv
module frac_cycle_counter
  import frac_div_pkg::*;
#(
  parameter int unsigned RESET_N = 512
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hold,
  input  logic [DIV_N_W-1:0] hold_n,
  input  logic [DIV_N_W-1:0] next_n,
  input  logic               carry,
  output logic               terminal
);
  localparam int unsigned CW = DIV_N_W + 1;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= CW'(RESET_N);
    else if (hold)       cnt <= CW'(hold_n);
    else if (cnt == '0)  cnt <= CW'(next_n) + CW'(carry) - CW'(1);
    else                 cnt <= cnt - CW'(1);
  end

  assign terminal = (cnt == '0) && !hold;
endmodule

// File: rtl/frac_comp_window.sv
module frac_comp_window #(
  parameter int unsigned WIN_LEN = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic start,
  output logic active
);
  localparam int unsigned WW = $clog2(WIN_LEN + 1);
  logic [WW-1:0] wcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           wcnt <= '0;
    else if (clear)       wcnt <= '0;
    else if (start)       wcnt <= WW'(WIN_LEN);
    else if (wcnt != '0)  wcnt <= wcnt - WW'(1);
  end

  assign active = (wcnt != '0);
endmodule

// File: rtl/frac_n_divider.sv
module frac_n_divider
  import frac_div_pkg::*;
#(
  parameter int unsigned N_MIN   = 512,
  parameter int unsigned RESET_N = 512,
  parameter int unsigned WIN_LEN = 128
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 pwr_down,
  input  logic                 cfg_valid,
  output logic                 cfg_ready,
  input  logic [DIV_N_W-1:0]   cfg_n,
  input  logic [DIV_NF_W-1:0]  cfg_nf,
  input  logic                 cfg_mod5,
  output logic                 div_pulse,
  output logic [DIV_ACC_W-1:0] acc_value,
  output logic                 comp_win
);
  div_cfg_t           in_cfg, nxt_cfg;
  logic [DIV_N_W-1:0] act_n;
  logic               mod_swap, carry, terminal;

  assign in_cfg = '{n: cfg_n, nf: cfg_nf, mod5: cfg_mod5};

  frac_cfg_shadow #(.N_MIN(N_MIN), .RESET_N(RESET_N)) u_shadow (
    .clk(clk), .rst_n(rst_n),
    .in_valid(cfg_valid), .in_ready(cfg_ready), .in_cfg(in_cfg),
    .boundary(terminal), .act_n(act_n), .nxt_cfg(nxt_cfg), .mod_swap(mod_swap)
  );

  frac_accum u_accum (
    .clk(clk), .rst_n(rst_n), .clear(pwr_down), .boundary(terminal),
    .mod_swap(mod_swap), .nf(nxt_cfg.nf), .mod5(nxt_cfg.mod5),
    .acc(acc_value), .carry(carry)
  );

  frac_cycle_counter #(.RESET_N(RESET_N)) u_count (
    .clk(clk), .rst_n(rst_n), .hold(pwr_down), .hold_n(act_n),
    .next_n(nxt_cfg.n), .carry(carry), .terminal(terminal)
  );

  frac_comp_window #(.WIN_LEN(WIN_LEN)) u_window (
    .clk(clk), .rst_n(rst_n), .clear(pwr_down), .start(terminal), .active(comp_win)
  );

  assign div_pulse = terminal;
endmodule

// File: rtl/frac_n_divider_chk.sv
module frac_n_divider_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       pwr_down,
  input logic       cfg_valid,
  input logic       cfg_ready,
  input logic       div_pulse,
  input logic [2:0] acc_value,
  input logic       comp_win
);
  assert_pulse_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    div_pulse |=> !div_pulse);

  assert_acc_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!div_pulse && !pwr_down) |=> $stable(acc_value));

  assert_ready_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid && cfg_ready) |=> !cfg_ready);

  assert_ready_wait_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_ready && !div_pulse) |=> !cfg_ready);

  assert_win_open_R9: assert property (@(posedge clk) disable iff (!rst_n)
    div_pulse |=> comp_win);

  assert_win_closed_R9: assert property (@(posedge clk) disable iff (!rst_n)
    div_pulse |-> !comp_win);

  assert_pd_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down |=> (acc_value == 3'd0 && !comp_win && !div_pulse));
endmodule

bind frac_n_divider frac_n_divider_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pwr_down(pwr_down), .cfg_valid(cfg_valid),
  .cfg_ready(cfg_ready), .div_pulse(div_pulse), .acc_value(acc_value),
  .comp_win(comp_win)
);

// File: tb/tb_frac_n_divider.sv
`timescale 1ns/1ps
module tb_frac_n_divider;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pwr_down = 1'b0;
  logic        cfg_valid = 1'b0;
  logic        cfg_ready;
  logic [15:0] cfg_n = '0;
  logic [2:0]  cfg_nf = '0;
  logic        cfg_mod5 = 1'b0;
  logic        div_pulse;
  logic [2:0]  acc_value;
  logic        comp_win;

  int checks = 0;
  int errors = 0;

  int m_n = 512, m_nf = 0, m_q = 8, m_acc = 0;
  bit p_pend = 0, p_clamp = 0;
  int p_n = 0, p_nf = 0, p_q = 8;

  always #4 clk = ~clk;

  frac_n_divider dut (
    .clk(clk), .rst_n(rst_n), .pwr_down(pwr_down), .cfg_valid(cfg_valid),
    .cfg_ready(cfg_ready), .cfg_n(cfg_n), .cfg_nf(cfg_nf), .cfg_mod5(cfg_mod5),
    .div_pulse(div_pulse), .acc_value(acc_value), .comp_win(comp_win)
  );

  task automatic check_eq(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic model_boundary(output int exp_int, output string tag_acc, output string tag_int);
    int nfe, s, carry;
    tag_acc = "R3";
    tag_int = "R2";
    carry   = 0;
    if (p_pend) begin
      tag_int = p_clamp ? "R8" : "R6";
      tag_acc = "R6";
      p_pend  = 0;
      if (p_q != m_q) begin
        m_n = p_n; m_nf = p_nf; m_q = p_q; m_acc = 0;
        exp_int = m_n;
        tag_acc = "R7";
        tag_int = "R7";
        return;
      end
      m_n = p_n; m_nf = p_nf; m_q = p_q;
    end
    nfe = m_nf;
    if (m_nf >= m_q) begin
      nfe = m_nf - m_q;
      tag_acc = "R4";
    end
    s = m_acc + nfe;
    if (s >= m_q) begin
      s = s - m_q;
      carry = 1;
      if (tag_int == "R2") tag_int = "R3";
    end
    m_acc = s;
    exp_int = m_n + carry;
  endtask

  // Entered at a negedge where div_pulse is high; returns at the next pulse.
  task automatic check_period(input bit do_load, input int ln, input int lnf, input bit lm5);
    int exp_int, cyc, win;
    string ta, ti;
    model_boundary(exp_int, ta, ti);
    cyc = 0;
    win = 0;
    while (cyc < 70000) begin
      @(negedge clk);
      cyc++;
      if (comp_win) win++;
      if (cyc == 1) begin
        check_eq(ta, "acc after pulse", int'(acc_value), m_acc);
        if (do_load) begin
          check_eq("R5", "ready before offer", int'(cfg_ready), 1);
          cfg_n = 16'(ln); cfg_nf = 3'(lnf); cfg_mod5 = lm5; cfg_valid = 1'b1;
        end
      end else if (cyc == 2 && do_load) begin
        cfg_valid = 1'b0;
        check_eq("R5", "ready after accept", int'(cfg_ready), 0);
        p_pend = 1; p_nf = lnf; p_q = lm5 ? 5 : 8;
        p_clamp = (ln < 512);
        p_n = p_clamp ? 512 : ln;
      end else if (cyc == 300) begin
        check_eq("R3", "acc held mid-period", int'(acc_value), m_acc);
      end
      if (div_pulse) break;
    end
    check_eq(ti, "interval", cyc, exp_int);
    check_eq("R9", "window length", win, 128);
  endtask

  task automatic reset_test();
    int cyc;
    repeat (4) @(negedge clk);
    check_eq("R1", "pulse in reset", int'(div_pulse), 0);
    check_eq("R1", "ready in reset", int'(cfg_ready), 1);
    rst_n = 1'b1;
    cyc = 0;
    while (cyc < 2000) begin
      @(negedge clk);
      cyc++;
      if (cyc == 1) begin
        check_eq("R1", "acc after reset", int'(acc_value), 0);
        check_eq("R1", "window after reset", int'(comp_win), 0);
        check_eq("R1", "ready after reset", int'(cfg_ready), 1);
      end
      if (div_pulse) break;
    end
    check_eq("R1", "first pulse", cyc, 512);
  endtask

  task automatic pd_test();
    int cyc, bad;
    @(negedge clk);
    repeat (200) @(negedge clk);
    pwr_down = 1'b1;
    bad = 0;
    repeat (300) begin
      @(negedge clk);
      if (div_pulse || comp_win || acc_value != 3'd0) bad++;
    end
    check_eq("R10", "activity while powered down", bad, 0);
    pwr_down = 1'b0;
    m_acc = 0;
    cyc = 0;
    while (cyc < 70000) begin
      @(negedge clk);
      cyc++;
      if (div_pulse) break;
    end
    check_eq("R10", "first interval after release", cyc, m_n);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    reset_test();
    check_period(0, 0, 0, 0);
    check_period(0, 0, 0, 0);
    // ratio 600, increment 3, modulus 8
    check_period(1, 600, 3, 0);
    repeat (9) check_period(0, 0, 0, 0);
    // increment 7 with modulus 5: modulus change then reduced increment
    check_period(1, 600, 7, 1);
    repeat (6) check_period(0, 0, 0, 0);
    // ratio below the floor
    check_period(1, 100, 1, 1);
    repeat (3) check_period(0, 0, 0, 0);
    pd_test();
    repeat (2) check_period(0, 0, 0, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule